// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the only master on a half-duplex, open-drain, single-wire bus. All signalling is done with timed low pulses on one shared line that an external pull-up holds high when nobody pulls it down. The block runs three operations: a reset pulse followed by a check for a slave's presence reply, a write of one byte, and a read of one byte. A byte always travels as eight back-to-back time slots, least significant bit first.

The host hands over work on a command channel with valid/ready handshaking. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low for the whole operation, so the host has to hold a command until the block is idle again. Anything offered while the block is busy is dropped. The result is not back-pressured. `done` pulses for one cycle when an operation ends. `rd_data` and `presence` keep their values until a later operation of the same kind replaces them.

On the bus side, `bus_pull_low` is an active-high enable for the external open-drain pull-down. `bus_in` is the raw level of the line, and a two-flop synchronizer brings it into the clock domain. A tick generator turns the system clock into one-microsecond steps. It restarts on every accepted command, so every pulse width is an exact multiple of `CLK_PER_US` cycles.

Top module: `swire_master`

## Requirements
- R1: After reset, `bus_pull_low`, `done`, `busy`, `presence` and `rd_data` are all 0, and `cmd_ready` is 1.
- R2: A reset command (op code 2'b01) pulls the line low for exactly 480 µs, which is well below 960 µs.
- R3: The line is sampled 70 µs after the reset pulse is released. `presence` becomes 1 if the line was low at that point and 0 otherwise. `done` rises 960 µs after the command is accepted.
- R4: A write command (op code 2'b10) sends `cmd_wdata` as eight slots, least significant bit first. A 1 bit is a 6 µs low pulse and a 0 bit is a 60 µs low pulse.
- R5: Within one byte, consecutive slots start exactly 70 µs apart. This leaves at least 10 µs of released line between slots.
- R6: A read command (op code 2'b11) opens each of its eight slots with a 6 µs low pulse. The line is sampled 12 µs after each slot starts, and the sampled bits are shifted in so that the first one ends up in `rd_data[0]`.
- R7: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. While an operation runs, `cmd_ready` is 0, `busy` is 1, and any command offered has no effect on the bus or the result.
- R8: `done` lasts exactly one cycle, and `cmd_ready` is already 1 in that cycle. `rd_data` for a read is valid when `done` is high.
- R9: During a byte slot the line is never held low as long as 61 µs, and no low pulse is longer than 480 µs.
- R10: Op code 2'b00 is not a command. When it is offered, `cmd_ready` stays 1 and the bus stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block is idle and will take a command |
| cmd_op | input | 2 | 01 reset, 10 write byte, 11 read byte, 00 none |
| cmd_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Byte from the last read |
| done | output | 1 | One-cycle pulse when an operation ends |
| busy | output | 1 | An operation is running |
| presence | output | 1 | A slave answered the last reset |
| bus_pull_low | output | 1 | Enable for the open-drain pull-down |
| bus_in | input | 1 | Raw line level |

## Verification
The assertions assume two things about the inputs. First, `bus_in` is a bus level that only the master and slaves pull low. Second, the host leaves `cmd_op` alone until its command has been taken. Nothing is assumed about when `cmd_valid` arrives. The bench drives the line through a slave model that only pulls low in response to the master's own falling edges, or in a presence window after a reset. It offers commands only at idle, except for one deliberate command injected in the middle of a byte and one offer of op code 00.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_SLOT
  } st_e;
endpackage

// File: rtl/swire_tick.sv
module swire_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div_q <= '0;
    else if (restart || div_q == LAST) div_q <= '0;
    else                            div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST) && !restart;

  generate
    if (CLK_PER_US > 1) begin : g_gap
      // R5: microsecond steps never come on back-to-back cycles
      p_tick_gap_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/swire_engine.sv
module swire_engine
  import swire_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES_SMP  = 70,
  parameter int T_RST_WIN   = 480,
  parameter int T_START     = 6,
  parameter int T_W0_LOW    = 60,
  parameter int T_RD_SMP    = 12,
  parameter int T_SLOT      = 70,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              restart,
  output logic              pull_low,
  output logic              done,
  output logic              presence,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int CW = $clog2(T_RST_LOW + T_RST_WIN + 1);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [CW-1:0] C_RL  = CW'(T_RST_LOW - 1);
  localparam logic [CW-1:0] C_PS  = CW'(T_PRES_SMP - 1);
  localparam logic [CW-1:0] C_RW  = CW'(T_RST_WIN - 1);
  localparam logic [CW-1:0] C_RS  = CW'(T_RD_SMP - 1);
  localparam logic [CW-1:0] C_SL  = CW'(T_SLOT - 1);
  localparam logic [CW-1:0] C_ST  = CW'(T_START);
  localparam logic [CW-1:0] C_W0  = CW'(T_W0_LOW);
  localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

  st_e               state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bidx_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              is_read_q;
  logic              samp_q;
  logic              accept;
  logic [CW-1:0]     low_len;
  logic              pull_next;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready && (cmd_op != OP_NONE);
  assign restart   = accept;

  always_comb begin
    if (is_read_q || shreg_q[0]) low_len = C_ST;
    else                         low_len = C_W0;
    case (state_q)
      ST_RST_LOW: pull_next = 1'b1;
      ST_SLOT:    pull_next = (cnt_q < low_len);
      default:    pull_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bidx_q    <= '0;
      shreg_q   <= '0;
      is_read_q <= 1'b0;
      samp_q    <= 1'b1;
      pull_low  <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
      rd_data   <= '0;
    end else begin
      pull_low <= pull_next;
      done     <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cnt_q  <= '0;
            bidx_q <= '0;
            if (cmd_op == OP_RESET) begin
              state_q <= ST_RST_LOW;
            end else if (cmd_op == OP_WRITE) begin
              state_q   <= ST_SLOT;
              is_read_q <= 1'b0;
              shreg_q   <= cmd_wdata;
            end else begin
              state_q   <= ST_SLOT;
              is_read_q <= 1'b1;
              shreg_q   <= '0;
            end
          end
        end
        ST_RST_LOW: begin
          if (tick) begin
            if (cnt_q == C_RL) begin
              cnt_q   <= '0;
              state_q <= ST_RST_WAIT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RST_WAIT: begin
          if (tick) begin
            if (cnt_q == C_PS) presence <= ~line;
            if (cnt_q == C_RW) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (is_read_q && cnt_q == C_RS) samp_q <= line;
            if (cnt_q == C_SL) begin
              cnt_q   <= '0;
              shreg_q <= {is_read_q & samp_q, shreg_q[BYTE_W-1:1]};
              bidx_q  <= bidx_q + 1'b1;
              if (bidx_q == B_LAST) begin
                state_q <= ST_IDLE;
                done    <= 1'b1;
                if (is_read_q) rd_data <= {samp_q, shreg_q[BYTE_W-1:1]};
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  localparam int LW = $clog2(T_RST_LOW * CLK_PER_US + 4);
  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= '0;
    else if (pull_low) low_run_q <= low_run_q + 1'b1;
    else               low_run_q <= '0;
  end

  p_reset_len_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= LW'(T_RST_LOW * CLK_PER_US));
  p_slot_len_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT) |-> low_run_q <= LW'(T_W0_LOW * CLK_PER_US));
  p_done_ready_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  p_done_single_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && $past(cmd_ready)) |-> !pull_low);
  p_busy_ignore_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cmd_valid && !tick) |=> $stable(shreg_q));
  p_pres_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RST_WAIT) |=> $stable(presence));
  p_rdata_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SLOT) |=> $stable(rd_data));
endmodule

// File: rtl/swire_master.sv
module swire_master #(
  parameter int CLK_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] rd_data,
  output logic       done,
  output logic       busy,
  output logic       presence,
  output logic       bus_pull_low,
  input  logic       bus_in
);
  logic tick;
  logic restart;
  logic line_s;

  swire_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  swire_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s)
  );

  swire_engine #(.CLK_PER_US(CLK_PER_US)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .restart(restart), .pull_low(bus_pull_low),
    .done(done), .presence(presence), .rd_data(rd_data)
  );

  assign busy = ~cmd_ready;
endmodule

// File: tb/tb_swire_master.sv
module tb_swire_master;
  localparam int CLK_PERIOD = 10;
  localparam int US = 4;
  localparam int US_T = US * CLK_PERIOD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       done, busy, presence, bus_pull_low;
  logic       slave_low = 1'b0;
  logic       bus_in;

  assign bus_in = ~(bus_pull_low | slave_low);

  swire_master #(.CLK_PER_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rd_data(rd_data), .done(done),
    .busy(busy), .presence(presence), .bus_pull_low(bus_pull_low),
    .bus_in(bus_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: expected low pulses (length in us, start spacing in us, tag)
  int    exp_len[$];
  int    exp_gap[$];
  string exp_req[$];

  // monitor
  int    cyc = 0;
  int    start_cyc = 0;
  int    cur_len = -1;
  string cur_req = "";
  logic  prev_pull = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && bus_pull_low && !prev_pull) begin
      if (exp_len.size() == 0) begin
        chk("R7/R10 unexpected pulse", 1, 0);
        cur_len = -1;
      end else begin
        int g;
        cur_len = exp_len.pop_front();
        g       = exp_gap.pop_front();
        cur_req = exp_req.pop_front();
        if (g > 0) chk({cur_req, " R5 spacing"}, cyc - start_cyc, g * US);
      end
      start_cyc = cyc;
    end else if (rst_n && !bus_pull_low && prev_pull && cur_len >= 0) begin
      chk({cur_req, " width"}, cyc - start_cyc, cur_len * US);
    end
    prev_pull = bus_pull_low;
  end

  // slave model: 0 idle, 1 presence, 2 read source
  int       smode = 0;
  bit       s_present = 1'b0;
  logic [7:0] s_byte = 8'h00;
  int       s_idx = 0;
  initial begin
    forever begin
      @(posedge bus_pull_low);
      if (smode == 2) begin
        logic b;
        b = s_byte[s_idx];
        s_idx++;
        if (!b) begin
          slave_low = 1'b1;
          #(25 * US_T);
          slave_low = 1'b0;
        end
      end else if (smode == 1) begin
        @(negedge bus_pull_low);
        #(20 * US_T);
        slave_low = s_present;
        #(100 * US_T);
        slave_low = 1'b0;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done) begin
      @(negedge clk);
      waited++;
    end
    chk("R8 ready with done", int'(cmd_ready), 1);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
  endtask

  task automatic do_reset(input bit present);
    int w;
    smode = 1; s_present = present;
    exp_len.push_back(480); exp_gap.push_back(0); exp_req.push_back("R2 reset");
    issue(2'b01, 8'h00);
    wait_done(w);
    chk("R3 done delay", w, 960 * US);
    chk("R3 presence", int'(presence), int'(present));
  endtask

  task automatic push_write(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_len.push_back(b[i] ? 6 : 60);
      exp_gap.push_back(i == 0 ? 0 : 70);
      exp_req.push_back("R4 write slot");
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    int w;
    smode = 0;
    push_write(b);
    issue(2'b10, b);
    wait_done(w);
  endtask

  task automatic read_byte(input logic [7:0] b);
    int w;
    smode = 2; s_byte = b; s_idx = 0;
    for (int i = 0; i < 8; i++) begin
      exp_len.push_back(6);
      exp_gap.push_back(i == 0 ? 0 : 70);
      exp_req.push_back("R6 read slot");
    end
    issue(2'b11, 8'h00);
    wait_done(w);
    chk("R6 read data", int'(rd_data), int'(b));
    smode = 0;
  endtask

  initial begin
    #(150000 * CLK_PERIOD);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pull", int'(bus_pull_low), 0);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 presence", int'(presence), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R10 op 00 ignored
    cmd_valid = 1'b1; cmd_op = 2'b00;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (50 * US) @(negedge clk);
    chk("R10 ready kept", int'(cmd_ready), 1);
    chk("R10 bus released", int'(bus_pull_low), 0);

    do_reset(1'b1);
    do_reset(1'b0);

    write_byte(8'hA5);
    write_byte(8'h00);
    write_byte(8'hFF);

    read_byte(8'h3C);
    read_byte(8'hFF);
    read_byte(8'h00);

    // R7: command offered mid-byte is ignored
    smode = 0;
    push_write(8'h96);
    issue(2'b10, 8'h96);
    repeat (100 * US) @(negedge clk);
    chk("R7 busy flag", int'(busy), 1);
    chk("R7 ready low", int'(cmd_ready), 0);
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    wait_done(w);
    chk("R7 rd_data untouched", int'(rd_data), 0);
    repeat (100 * US) @(negedge clk);
    chk("R7 scoreboard drained", exp_len.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule